// File: doc/BRIEF.md
# Elevator Call Latch and Next-Stop Scheduler

This block keeps track of every outstanding call in a four-floor lift and picks the floor where the car should stop next. There are three kinds of call. Car buttons exist on every floor. Up hall buttons exist on every floor except the top one. Down hall buttons exist on every floor except the ground floor. Each press sets a sticky flag. The flag stays set until the car reports that it has served that floor.

The next stop is chosen by a sweep that favours the current direction of travel. While rising, the block first takes calls at or above the car that can be answered on the way up. It then takes down calls from the top downwards, and after that the remaining calls below the car in ascending order. Falling is the mirror image of rising. When no call is pending, the block returns floor 0 so that the car parks at the ground floor.

The controller that owns the motor and the door feeds back three signals: the current floor, the direction, and a one-cycle served strobe. It reads back a registered next-stop floor.

Top module: `lift_sched`

## Requirements
- R1: A car button press sets that floor's car call. The call stays set in every later cycle until that floor is served.
- R2: An up hall press (floors 0 to 2) or a down hall press (floors 1 to 3) sets the matching hall call. The call is sticky in the same way as a car call.
- R3: A served strobe clears the car call at the current floor and the hall call at that floor for the current direction (direction 1 = up, 0 = down). The opposite-direction hall call at that floor is kept.
- R4: At the end floors the served strobe clears the only hall call present. Serving floor 3 clears its down call whatever the direction. Serving floor 0 clears its up call whatever the direction.
- R5: A press arriving in the same cycle as a served strobe for the same floor and call stays latched.
- R6: While rising from floor c, the search order is as follows. First, car or up calls at floors c up to 2. Second, a car or down call at floor 3. Third, down calls from floor 2 down to floor 1. Last, car or up calls at floors 0 up to c-1.
- R7: While falling from floor c, the search order is as follows. First, car or down calls at floors c down to 1. Second, a car or up call at floor 0. Third, up calls from floor 1 up to floor 2. Last, car or down calls at floors 3 down to c+1.
- R8: With no call pending, the next stop is floor 0.
- R9: A synchronous reset clears all calls and sets the next stop to 0. Presses during reset are dropped.
- R10: A press latched at clock edge k first affects the next-stop output after edge k+1. Changes to the floor and direction inputs take effect with the same one-edge delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_btn | input | FLOORS | Car button per floor, bit i = floor i |
| hall_up_btn | input | FLOORS-1 | Up hall button, bit i = floor i |
| hall_dn_btn | input | FLOORS-1 | Down hall button, bit i = floor i+1 |
| cur_floor | input | FW | Floor the car is at |
| dir_up | input | 1 | Travel direction, 1 = up, 0 = down |
| served | input | 1 | One-cycle strobe: the current floor has been served |
| next_stop | output | FW | Registered next floor to stop at |

## Verification
Setting a call and clearing it can fall in the same cycle when a passenger presses a button on the floor that is being served. The bench provokes this by raising a car button, and separately a down hall button, in the very cycle that carries the served strobe for that floor. It then moves the car elsewhere and judges the outcome by whether the next-stop output still points at the served floor. The order of the sweep is judged by clearing the winning call step by step and watching the next choice.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } lift_dir_e;
endpackage

// File: rtl/lift_call_latch.sv
module lift_call_latch #(
  parameter int FLOORS = 4,
  localparam int FW = $clog2(FLOORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOORS-1:0] car_btn,
  input  logic [FLOORS-2:0] up_btn,
  input  logic [FLOORS-2:0] dn_btn,
  input  logic [FW-1:0]     cur_floor,
  input  logic              dir_up,
  input  logic              served,
  output logic [FLOORS-1:0] car_q,
  output logic [FLOORS-1:0] up_q,
  output logic [FLOORS-1:0] dn_q
);
  import lift_pkg::*;

  for (genvar F = 0; F < FLOORS; F++) begin : g_floor
    logic at_here;
    logic car_r;
    assign at_here = served && (cur_floor == FW'(F));

    always_ff @(posedge clk) begin
      if (rst) car_r <= 1'b0;
      else     car_r <= car_btn[F] | (car_r & ~at_here);
    end
    assign car_q[F] = car_r;

    assert_car_set_R1: assert property (@(posedge clk) disable iff (rst)
      car_btn[F] |=> car_q[F]);
    assert_car_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (car_q[F] && !at_here) |=> car_q[F]);
    assert_car_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (at_here && !car_btn[F]) |=> !car_q[F]);

    if (F < FLOORS - 1) begin : g_up
      logic up_r;
      logic up_clr;
      assign up_clr = at_here && (dir_up == DIR_UP || F == 0);
      always_ff @(posedge clk) begin
        if (rst) up_r <= 1'b0;
        else     up_r <= up_btn[F] | (up_r & ~up_clr);
      end
      assign up_q[F] = up_r;
      assert_up_set_R2: assert property (@(posedge clk) disable iff (rst)
        up_btn[F] |=> up_q[F]);
      assert_up_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (up_clr && !up_btn[F]) |=> !up_q[F]);
    end else begin : g_no_up
      assign up_q[F] = 1'b0;
    end

    if (F > 0) begin : g_dn
      logic dn_r;
      logic dn_clr;
      assign dn_clr = at_here && (dir_up == DIR_DN || F == FLOORS - 1);
      always_ff @(posedge clk) begin
        if (rst) dn_r <= 1'b0;
        else     dn_r <= dn_btn[F-1] | (dn_r & ~dn_clr);
      end
      assign dn_q[F] = dn_r;
      assert_dn_set_R2: assert property (@(posedge clk) disable iff (rst)
        dn_btn[F-1] |=> dn_q[F]);
      assert_dn_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (dn_clr && dn_btn[F-1]) |=> dn_q[F]);
    end else begin : g_no_dn
      assign dn_q[F] = 1'b0;
    end
  end
endmodule

// File: rtl/lift_sweep_pick.sv
module lift_sweep_pick #(
  parameter int FLOORS = 4,
  localparam int FW = $clog2(FLOORS)
) (
  input  logic [FLOORS-1:0] car_q,
  input  logic [FLOORS-1:0] up_q,
  input  logic [FLOORS-1:0] dn_q,
  input  logic [FW-1:0]     cur_floor,
  input  logic              dir_up,
  output logic [FW-1:0]     pick
);
  logic found;
  int   cur;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    cur   = int'(cur_floor);
    if (dir_up) begin
      // ahead of the car, answerable on the way up
      for (int f = 0; f < FLOORS; f++)
        if (!found && f >= cur &&
            (car_q[f] || up_q[f] || (f == FLOORS - 1 && dn_q[f]))) begin
          pick = FW'(f); found = 1'b1;
        end
      // return sweep: down calls from the top
      for (int f = FLOORS - 1; f >= 0; f--)
        if (!found && dn_q[f]) begin
          pick = FW'(f); found = 1'b1;
        end
      // remainder below the car, ascending
      for (int f = 0; f < FLOORS; f++)
        if (!found && f < cur && (car_q[f] || up_q[f])) begin
          pick = FW'(f); found = 1'b1;
        end
    end else begin
      for (int f = FLOORS - 1; f >= 0; f--)
        if (!found && f <= cur &&
            (car_q[f] || dn_q[f] || (f == 0 && up_q[f]))) begin
          pick = FW'(f); found = 1'b1;
        end
      for (int f = 0; f < FLOORS; f++)
        if (!found && up_q[f]) begin
          pick = FW'(f); found = 1'b1;
        end
      for (int f = FLOORS - 1; f >= 0; f--)
        if (!found && f > cur && (car_q[f] || dn_q[f])) begin
          pick = FW'(f); found = 1'b1;
        end
    end
  end
endmodule

// File: rtl/lift_sched.sv
module lift_sched #(
  parameter int FLOORS = 4,
  localparam int FW = $clog2(FLOORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOORS-1:0] car_btn,
  input  logic [FLOORS-2:0] hall_up_btn,
  input  logic [FLOORS-2:0] hall_dn_btn,
  input  logic [FW-1:0]     cur_floor,
  input  logic              dir_up,
  input  logic              served,
  output logic [FW-1:0]     next_stop
);
  logic [FLOORS-1:0] car_q, up_q, dn_q, pend_all;
  logic [FW-1:0]     pick;

  lift_call_latch #(.FLOORS(FLOORS)) u_latch (
    .clk(clk), .rst(rst), .car_btn(car_btn), .up_btn(hall_up_btn),
    .dn_btn(hall_dn_btn), .cur_floor(cur_floor), .dir_up(dir_up),
    .served(served), .car_q(car_q), .up_q(up_q), .dn_q(dn_q)
  );

  lift_sweep_pick #(.FLOORS(FLOORS)) u_pick (
    .car_q(car_q), .up_q(up_q), .dn_q(dn_q), .cur_floor(cur_floor),
    .dir_up(dir_up), .pick(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) next_stop <= '0;
    else     next_stop <= pick;
  end

  assign pend_all = car_q | up_q | dn_q;

  assert_reset_home_R9: assert property (@(posedge clk)
    rst |=> (next_stop == '0));
  assert_idle_home_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_all == '0) |=> (next_stop == '0));
  assert_pick_pending_R10: assert property (@(posedge clk) disable iff (rst)
    (pend_all != '0) |=> ((($past(pend_all) >> next_stop) & FLOORS'(1)) != '0));
  assert_here_first_R6: assert property (@(posedge clk) disable iff (rst)
    (dir_up && car_q[cur_floor]) |=> (next_stop == $past(cur_floor)));
  assert_here_first_R7: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && car_q[cur_floor]) |=> (next_stop == $past(cur_floor)));
endmodule

// File: tb/lift_sched_test.sv
`timescale 1ns/1ps
module lift_sched_test;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] car_btn = '0;
  logic [2:0] hall_up_btn = '0;
  logic [2:0] hall_dn_btn = '0;
  logic [1:0] cur_floor = '0;
  logic       dir_up = 1'b1;
  logic       served = 1'b0;
  logic [1:0] next_stop;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lift_sched #(.FLOORS(N)) uut (
    .clk(clk), .rst(rst), .car_btn(car_btn), .hall_up_btn(hall_up_btn),
    .hall_dn_btn(hall_dn_btn), .cur_floor(cur_floor), .dir_up(dir_up),
    .served(served), .next_stop(next_stop)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: next_stop=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // kind 0 = car, 1 = hall up, 2 = hall down
  task automatic press(input int kind, input int f);
    if (kind == 0) car_btn[f] = 1'b1;
    else if (kind == 1) hall_up_btn[f] = 1'b1;
    else hall_dn_btn[f-1] = 1'b1;
    step();
    car_btn = '0; hall_up_btn = '0; hall_dn_btn = '0;
  endtask

  task automatic serve(input int f, input bit up);
    cur_floor = 2'(f); dir_up = up; served = 1'b1;
    step();
    served = 1'b0;
  endtask

  task automatic look(input int f, input bit up);
    cur_floor = 2'(f); dir_up = up;
    step(); step();
  endtask

  task automatic t_reset();
    rst = 1'b1; car_btn[3] = 1'b1;
    step(); step();
    car_btn = '0; rst = 1'b0;
    step();
    chk("R9 reset state", int'(next_stop), 0);
    step();
    chk("R9 press in reset dropped", int'(next_stop), 0);
  endtask

  task automatic t_latency();
    look(0, 1'b1);
    car_btn[2] = 1'b1;
    step();
    chk("R10 not yet visible", int'(next_stop), 0);
    car_btn = '0;
    step();
    chk("R10 visible one edge later", int'(next_stop), 2);
    repeat (5) step();
    chk("R1 car call sticky", int'(next_stop), 2);
    serve(2, 1'b1);
    look(2, 1'b1);
    chk("R3 car call cleared, R8 home", int'(next_stop), 0);
  endtask

  task automatic t_rise();
    press(1, 0); press(2, 1); press(2, 2); press(2, 3); press(0, 1);
    look(2, 1'b1);
    chk("R6 top down call first", int'(next_stop), 3);
    serve(3, 1'b1);
    look(2, 1'b1);
    chk("R4 top down cleared rising, R6 down2 next", int'(next_stop), 2);
    serve(2, 1'b0);
    look(2, 1'b1);
    chk("R6 down1 after down2", int'(next_stop), 1);
    serve(1, 1'b0);
    press(0, 3);
    look(2, 1'b1);
    chk("R6 car above beats up0 below", int'(next_stop), 3);
    serve(3, 1'b1);
    look(2, 1'b1);
    chk("R6 up0 last", int'(next_stop), 0);
    serve(0, 1'b1);
    press(2, 1); press(2, 2);
    look(0, 1'b1);
    chk("R6 down calls from the top", int'(next_stop), 2);
    serve(2, 1'b0);
    look(0, 1'b1);
    chk("R2 down1 latched", int'(next_stop), 1);
    serve(1, 1'b0);
  endtask

  task automatic t_fall();
    press(2, 3); press(1, 2); press(1, 1); press(1, 0); press(0, 2);
    look(1, 1'b0);
    chk("R7 floor0 up first", int'(next_stop), 0);
    serve(0, 1'b0);
    look(1, 1'b0);
    chk("R4 up0 cleared falling, R7 up1", int'(next_stop), 1);
    serve(1, 1'b1);
    look(1, 1'b0);
    chk("R7 up2 next", int'(next_stop), 2);
    serve(2, 1'b1);
    look(1, 1'b0);
    chk("R7 down3 last", int'(next_stop), 3);
    press(0, 0);
    look(1, 1'b0);
    chk("R7 car below beats down3", int'(next_stop), 0);
    serve(0, 1'b0);
    serve(3, 1'b0);
    look(3, 1'b0);
    chk("R8 empty goes home", int'(next_stop), 0);
  endtask

  task automatic t_opposite();
    press(1, 1); press(2, 1);
    serve(1, 1'b1);
    look(0, 1'b1);
    chk("R3 opposite hall call kept", int'(next_stop), 1);
    serve(1, 1'b0);
    look(3, 1'b1);
    chk("R3 down1 cleared", int'(next_stop), 0);
  endtask

  task automatic t_collide();
    cur_floor = 2'd2; dir_up = 1'b1; served = 1'b1; car_btn[2] = 1'b1;
    step();
    served = 1'b0; car_btn = '0;
    look(0, 1'b1);
    chk("R5 car press during serve kept", int'(next_stop), 2);
    serve(2, 1'b1);
    cur_floor = 2'd2; dir_up = 1'b0; served = 1'b1; hall_dn_btn[1] = 1'b1;
    step();
    served = 1'b0; hall_dn_btn = '0;
    look(0, 1'b1);
    chk("R5 hall press during serve kept", int'(next_stop), 2);
    serve(2, 1'b0);
    look(3, 1'b0);
    chk("R5 cleared afterwards", int'(next_stop), 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_rise();
    t_fall();
    t_opposite();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule